// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a sparse two-level translation table kept in memory. A root register, which can only be loaded while the privileged input is high, names the frame that holds the top-level table. For each request the walker reads one top-level entry, follows it to a second-level table, reads the leaf entry and then either returns the physical address or reports a page fault with a cause code.

Every table entry is a 32-bit word: a 26-bit frame number in the upper bits and six flag bits in the lower bits, of which three grant read, write and execute. A page whose three grant bits are all clear is absent. Clearing them on the leaf for virtual page 0 is how null-pointer accesses are made to trap. Memory is reached through a one-cycle request pulse and a response strobe that may come back after any number of cycles. Only one translation is in progress at a time.

Top module: `pt_walker`

## Requirements
- R1: A successful translation returns `res_paddr = {leaf frame, vaddr[11:0]}`, which is 38 bits wide. The 12 offset bits pass through unchanged.
- R2: Entry layout: bits [31:6] are the frame number, bit 0 grants read, bit 1 grants write, bit 2 grants execute, and bits [5:3] have no effect on the result.
- R3: The first read goes to `{root,12'h000} + vaddr[31:22]*4`. The second read goes to `{first-level frame,12'h000} + vaddr[21:12]*4`.
- R4: A first-level entry with bits [2:0] all zero ends the walk with fault cause 1 (absent), and no second read is issued.
- R5: A leaf entry with bits [2:0] all zero gives fault cause 1 (absent).
- R6: The access code is 0 for read, 1 for write and 2 for fetch. If the leaf is present but lacks the matching grant bit, the result is fault cause 2 (permission). A success reports cause 0. A fault drives `res_paddr` to zero.
- R7: The root register is loaded from `root_wr_frame` only when `root_wr_en` and `root_priv` are both high. Reset clears it to zero.
- R8: `req_ready` goes low in the cycle after a request is accepted. It stays low until the one-cycle `res_valid` pulse has ended.
- R9: Each table read is a one-cycle `mem_req_valid` pulse. The walker waits any number of cycles for `mem_rsp_valid`.
- R10: After reset, `req_ready` is 1 and both `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_wr_en | input | 1 | Root register load strobe |
| root_priv | input | 1 | Privilege qualifier for the root load |
| root_wr_frame | input | 26 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mem_req_valid | output | 1 | Table read request pulse |
| mem_req_addr | output | 38 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table entry returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Translation failed |
| res_cause | output | 2 | 0 none, 1 absent, 2 permission |
| res_paddr | output | 38 | Physical address, zero on a fault |

## Verification
A table of eleven translations is run against one fixed pair of tables. The table mixes the following cases:
- a leaf with only the reserved bits set, which separates absent from present;
- read, write and fetch against single-grant leaves, which separate a permission fault from success;
- an all-ones frame and offset, which exposes truncated address concatenation;
- an empty first-level slot, which must stop after one read;
- top-of-range indices, which check the entry address arithmetic.

Response latencies from zero to nine cycles show that the wait states do not lose a strobe. Directed walks around root loads with and without privilege show whether the guard works and which table base the first read uses.

// File: rtl/pt_walker_pkg.sv
// Package: shared codes for the two-level walker.
// Assumes entries keep their grant bits in the lowest three positions.
package pt_walker_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } access_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PERM   = 2'd2
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ_L1 = 3'd1,
        ST_WAIT_L1 = 3'd2,
        ST_READ_L2 = 3'd3,
        ST_WAIT_L2 = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;

    localparam int GRANT_R = 0;
    localparam int GRANT_W = 1;
    localparam int GRANT_X = 2;
endpackage

// File: rtl/pt_root_reg.sv
// Module: holds the frame number of the top-level table.
// Assumes a load is honoured only when the privilege input is high.
module pt_root_reg #(
    parameter int FRAME_W = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               priv,
    input  logic [FRAME_W-1:0] wr_frame,
    output logic [FRAME_W-1:0] root_frame
);
    // Guarded load of the root frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_frame <= '0;
        end else if (wr_en && priv) begin
            root_frame <= wr_frame;
        end
    end
endmodule

// File: rtl/pt_addr_gen.sv
// Module: forms the byte address of a table entry.
// Assumes tables are page aligned and entries are 2**ENTRY_LG bytes.
module pt_addr_gen #(
    parameter int FRAME_W  = 26,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 10,
    parameter int ENTRY_LG = 2,
    localparam int PA_W    = FRAME_W + OFF_W
) (
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [PA_W-1:0]    addr
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;

    // Table base plus scaled index.
    always_comb begin
        base = {tbl_frame, {OFF_W{1'b0}}};
        disp = PA_W'(idx) << ENTRY_LG;
        addr = base + disp;
    end
endmodule

// File: rtl/pt_entry_check.sv
// Module: decodes one table entry and tests it against the access kind.
// Assumes grant bits R, W and X sit in the lowest three flag positions.
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int ENTRY_W = 32,
    parameter int FRAME_W = 26,
    localparam int FLAG_W = ENTRY_W - FRAME_W
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         access,
    output logic               present,
    output logic               allowed,
    output logic [FRAME_W-1:0] frame
);
    localparam logic [FLAG_W-1:0] GRANT_MASK = FLAG_W'(3'b111);
    logic [FLAG_W-1:0] grants;

    // Split the entry and look up the grant for the access kind.
    always_comb begin
        frame   = entry[ENTRY_W-1 -: FRAME_W];
        grants  = entry[FLAG_W-1:0] & GRANT_MASK;
        present = |grants;
        unique case (access)
            ACC_READ:  allowed = grants[GRANT_R];
            ACC_WRITE: allowed = grants[GRANT_W];
            ACC_FETCH: allowed = grants[GRANT_X];
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/pt_walk_fsm.sv
// Module: sequences the two table reads and builds the result.
// Assumes memory returns exactly one response per request pulse.
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 10,
    parameter int FRAME_W = 26,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_access,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               mem_rsp_valid,
    input  logic               chk_present,
    input  logic               chk_allowed,
    input  logic [FRAME_W-1:0] chk_frame,
    output logic               mem_req_valid,
    output logic [FRAME_W-1:0] gen_frame,
    output logic [IDX_W-1:0]   gen_idx,
    output logic [1:0]         access_q,
    output logic               res_valid,
    output logic               res_fault,
    output logic [1:0]         res_cause,
    output logic [PA_W-1:0]    res_paddr
);
    walk_state_e        state;
    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] l2_tbl_q;
    logic               second_lvl;

    // Walk state, captured request and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            access_q  <= '0;
            l2_tbl_q  <= '0;
            res_fault <= 1'b0;
            res_cause <= CAUSE_NONE;
            res_paddr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_vaddr;
                        access_q <= req_access;
                        state    <= ST_READ_L1;
                    end
                end
                ST_READ_L1: state <= ST_WAIT_L1;
                ST_WAIT_L1: begin
                    if (mem_rsp_valid) begin
                        if (!chk_present) begin
                            res_fault <= 1'b1;
                            res_cause <= CAUSE_ABSENT;
                            res_paddr <= '0;
                            state     <= ST_DONE;
                        end else begin
                            l2_tbl_q <= chk_frame;
                            state    <= ST_READ_L2;
                        end
                    end
                end
                ST_READ_L2: state <= ST_WAIT_L2;
                ST_WAIT_L2: begin
                    if (mem_rsp_valid) begin
                        if (!chk_present) begin
                            res_fault <= 1'b1;
                            res_cause <= CAUSE_ABSENT;
                            res_paddr <= '0;
                        end else if (!chk_allowed) begin
                            res_fault <= 1'b1;
                            res_cause <= CAUSE_PERM;
                            res_paddr <= '0;
                        end else begin
                            res_fault <= 1'b0;
                            res_cause <= CAUSE_NONE;
                            res_paddr <= {chk_frame, va_q[OFF_W-1:0]};
                        end
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs and address-generator operand select.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        res_valid     = (state == ST_DONE);
        mem_req_valid = (state == ST_READ_L1) || (state == ST_READ_L2);
        second_lvl    = (state == ST_READ_L2) || (state == ST_WAIT_L2);
        gen_frame     = second_lvl ? l2_tbl_q : root_frame;
        gen_idx       = second_lvl ? va_q[OFF_W +: IDX_W] : va_q[VA_W-1 -: IDX_W];
    end
endmodule

// File: rtl/pt_walker.sv
// Module: top of the two-level page table walker.
// Assumes VA_W equals OFF_W plus two table indices.
module pt_walker #(
    parameter int VA_W     = 32,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 10,
    parameter int FRAME_W  = 26,
    parameter int ENTRY_W  = 32,
    localparam int PA_W    = FRAME_W + OFF_W,
    localparam int ENTRY_LG = $clog2(ENTRY_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               root_wr_en,
    input  logic               root_priv,
    input  logic [FRAME_W-1:0] root_wr_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_access,
    output logic               mem_req_valid,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               res_valid,
    output logic               res_fault,
    output logic [1:0]         res_cause,
    output logic [PA_W-1:0]    res_paddr
);
    logic [FRAME_W-1:0] root_frame;
    logic [FRAME_W-1:0] gen_frame;
    logic [IDX_W-1:0]   gen_idx;
    logic [1:0]         access_q;
    logic               chk_present;
    logic               chk_allowed;
    logic [FRAME_W-1:0] chk_frame;

    pt_root_reg #(.FRAME_W(FRAME_W)) u_root (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (root_wr_en),
        .priv       (root_priv),
        .wr_frame   (root_wr_frame),
        .root_frame (root_frame)
    );

    pt_addr_gen #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W),
        .IDX_W   (IDX_W),
        .ENTRY_LG(ENTRY_LG)
    ) u_agen (
        .tbl_frame (gen_frame),
        .idx       (gen_idx),
        .addr      (mem_req_addr)
    );

    pt_entry_check #(
        .ENTRY_W (ENTRY_W),
        .FRAME_W (FRAME_W)
    ) u_echk (
        .entry   (mem_rsp_data),
        .access  (access_q),
        .present (chk_present),
        .allowed (chk_allowed),
        .frame   (chk_frame)
    );

    pt_walk_fsm #(
        .VA_W    (VA_W),
        .OFF_W   (OFF_W),
        .IDX_W   (IDX_W),
        .FRAME_W (FRAME_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_access    (req_access),
        .root_frame    (root_frame),
        .mem_rsp_valid (mem_rsp_valid),
        .chk_present   (chk_present),
        .chk_allowed   (chk_allowed),
        .chk_frame     (chk_frame),
        .mem_req_valid (mem_req_valid),
        .gen_frame     (gen_frame),
        .gen_idx       (gen_idx),
        .access_q      (access_q),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_cause     (res_cause),
        .res_paddr     (res_paddr)
    );
endmodule

// File: rtl/pt_walker_checker.sv
// Module: temporal checks on the walker's ports and root state.
// Assumes it is bound into pt_walker with the names listed below.
module pt_walker_checker #(
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 26,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [OFF_W-1:0]   req_off,
    input logic               mem_req_valid,
    input logic               res_valid,
    input logic               res_fault,
    input logic [1:0]         res_cause,
    input logic [PA_W-1:0]    res_paddr,
    input logic               root_wr_en,
    input logic               root_priv,
    input logic [FRAME_W-1:0] root_q
);
    logic [OFF_W-1:0] off_q;

    // Remember the offset of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (req_valid && req_ready) begin
            off_q <= req_off;
        end
    end

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_paddr[OFF_W-1:0] == off_q));

    assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> ((res_paddr == '0) && (res_cause != 2'd0)));

    assert_ok_no_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_cause == 2'd0));

    assert_root_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(root_wr_en && root_priv) |=> $stable(root_q));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_mem_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
endmodule

bind pt_walker pt_walker_checker #(
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .mem_req_valid (mem_req_valid),
    .res_valid     (res_valid),
    .res_fault     (res_fault),
    .res_cause     (res_cause),
    .res_paddr     (res_paddr),
    .root_wr_en    (root_wr_en),
    .root_priv     (root_priv),
    .root_q        (root_frame)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic        root_priv = 1'b0;
    logic [25:0] root_wr_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        mem_req_valid;
    logic [37:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_fault;
    logic [1:0]  res_cause;
    logic [37:0] res_paddr;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int rd_cnt = 0;
    int back_to_back = 0;
    logic [37:0] rd_addr [4];
    logic [31:0] mem [logic [37:0]];

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .root_wr_en(root_wr_en), .root_priv(root_priv),
        .root_wr_frame(root_wr_frame), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
        .res_cause(res_cause), .res_paddr(res_paddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector table: address, access, fault, cause, paddr, reads, first and second read address.
    localparam logic [31:0] V_VA [NV] = '{32'h00000123, 32'h00001ABC, 32'h00001ABC,
        32'h00001000, 32'h00002FFF, 32'h00002000, 32'h00003010, 32'h00003010,
        32'h00400000, 32'hFFFFF7FF, 32'hFFFFF7FF};
    localparam logic [1:0] V_ACC [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd2, 2'd0,
        2'd0, 2'd1, 2'd0};
    localparam logic V_FLT [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
        1'b1, 1'b0, 1'b1};
    localparam logic [1:0] V_CAU [NV] = '{2'd1, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2,
        2'd1, 2'd0, 2'd2};
    localparam logic [37:0] V_PA [NV] = '{38'h0, 38'h1234ABC, 38'h0, 38'h0,
        38'h3FFFFFFFFF, 38'h3FFFFFF000, 38'h55010, 38'h0, 38'h0, 38'hABC7FF, 38'h0};
    localparam int V_NRD [NV] = '{2, 2, 2, 2, 2, 2, 2, 2, 1, 2, 2};
    localparam logic [37:0] V_A1 [NV] = '{38'h10000, 38'h10000, 38'h10000, 38'h10000,
        38'h10000, 38'h10000, 38'h10000, 38'h10000, 38'h10004, 38'h10FFC, 38'h10FFC};
    localparam logic [37:0] V_A2 [NV] = '{38'h20000, 38'h20004, 38'h20004, 38'h20004,
        38'h20008, 38'h20008, 38'h2000C, 38'h2000C, 38'h0, 38'h21FFC, 38'h21FFC};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: answers each request pulse after lat extra cycles.
    initial begin
        int cnt = 0;
        logic [31:0] pend = '0;
        logic prev_req = 1'b0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = pend;
                end
            end
            if (mem_req_valid && prev_req) back_to_back++;
            if (mem_req_valid) begin
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt++;
                pend = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                cnt = lat + 1;
            end
            prev_req = mem_req_valid;
        end
    end

    task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                        output logic f, output logic [1:0] c, output logic [37:0] pa);
        int n = 0;
        rd_cnt = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_access = acc;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", req_ready, 1'b0);
        while (!res_valid && n < 100) begin
            @(negedge clk);
            n++;
            if (!res_valid) chk("R8 busy during walk", req_ready, 1'b0);
        end
        f = res_fault; c = res_cause; pa = res_paddr;
        chk("R8 result seen", res_valid, 1'b1);
        @(negedge clk);
        chk("R8 result one cycle", res_valid, 1'b0);
    endtask

    task automatic load_root(input logic [25:0] fr, input logic pv);
        @(negedge clk);
        root_wr_en = 1'b1; root_priv = pv; root_wr_frame = fr;
        @(negedge clk);
        root_wr_en = 1'b0; root_priv = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic f;
        logic [1:0] c;
        logic [37:0] pa;
        // Table contents: entry = {frame, flags}; R bit0, W bit1, X bit2.
        mem[38'h10000] = {26'h20, 6'b000001};
        mem[38'h10FFC] = {26'h21, 6'b000111};
        mem[38'h20000] = {26'h777, 6'b111000};
        mem[38'h20004] = {26'h1234, 6'b000001};
        mem[38'h20008] = {26'h3FFFFFF, 6'b000111};
        mem[38'h2000C] = {26'h55, 6'b000100};
        mem[38'h21FFC] = {26'hABC, 6'b000010};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", req_ready, 1'b1);
        chk("R10 no result after reset", res_valid, 1'b0);
        chk("R10 no read after reset", mem_req_valid, 1'b0);

        // Root is zero after reset: first read at index 1 * 4.
        walk(32'h00400000, 2'd0, f, c, pa);
        chk("R7 reset root address", rd_addr[0], 38'h4);
        chk("R4 empty first level", c, 2'd1);

        load_root(26'h10, 1'b1);
        for (int i = 0; i < NV; i++) begin
            lat = i % 4;
            walk(V_VA[i], V_ACC[i], f, c, pa);
            chk("R6 fault flag", f, V_FLT[i]);
            chk("R5 R6 cause", c, V_CAU[i]);
            chk("R1 R2 paddr", pa, V_PA[i]);
            chk("R4 read count", rd_cnt, V_NRD[i]);
            chk("R3 first read address", rd_addr[0], V_A1[i]);
            if (V_NRD[i] == 2) chk("R3 second read address", rd_addr[1], V_A2[i]);
        end

        // Long latency walk.
        lat = 9;
        walk(32'h00002FFF, 2'd1, f, c, pa);
        chk("R9 long latency paddr", pa, 38'h3FFFFFFFFF);

        // Unprivileged root load has no effect.
        lat = 1;
        load_root(26'h30, 1'b0);
        walk(32'h00001ABC, 2'd0, f, c, pa);
        chk("R7 unprivileged load ignored", rd_addr[0], 38'h10000);
        chk("R7 translation unchanged", pa, 38'h1234ABC);

        // Privileged load moves the table base.
        load_root(26'h40, 1'b1);
        walk(32'h00001ABC, 2'd0, f, c, pa);
        chk("R7 privileged load used", rd_addr[0], 38'h40000);
        chk("R4 empty table single read", rd_cnt, 1);
        chk("R4 empty table fault", f, 1'b1);

        chk("R9 request pulses single cycle", back_to_back, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule